// File: doc/BRIEF.md
# Full-duplex serial frame port (start + 8 data + stop)

This block is an asynchronous serial transceiver that moves bytes in ten-bit frames. Each frame has a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts sixteen ticks of an oversampling strobe. The transmitter and the receiver each take their own strobe, so the two directions can run at different rates. The strobes come from outside the block.

Software starts a transmission by writing a byte. The transmitter raises a sticky "transmit done" flag as soon as the stop bit begins.

The receiver is armed by an enable input and looks for a falling edge on the line. It checks the start bit in the middle of the bit and decides each bit by a three-sample majority vote. At the end of a frame it stores the byte and the sampled stop bit only when the "receive done" flag is clear. When the strict-stop option is on, the sampled stop bit must also be high.

The hardware only ever sets the two flags. Software clears them with clear strobes. An interrupt request follows either flag when interrupts are enabled.

Top module: `sio_frame_port`

## Requirements
- R1: While idle, `txd` is high. A frame on `txd` is: start bit 0, then `wr_byte` bits 0..7 in that order, then stop bit 1. Each bit lasts 16 `tx_tick` strobes.
- R2: A `wr_en` strobe while the transmitter is idle starts a frame. A `wr_en` strobe during a frame is ignored: the current frame is not altered and no extra frame follows.
- R3: `tx_done` rises at the start of the stop bit, well before the stop bit ends. It stays high until it is cleared.
- R4: A falling edge on `rxd` starts reception only while `rx_enable` is 1. A frame that arrives while `rx_enable` is 0 changes neither `rx_data` nor `rx_done`.
- R5: If `rxd` is high again at the 8th `rx_tick` after the falling edge, the start is rejected. The receiver returns to idle and stores nothing.
- R6: Each received bit is the majority of the line samples taken at `rx_tick` 7, 8 and 9 of its 16-tick period. Line activity outside those ticks does not change the result.
- R7: At the end of a frame, if `rx_done` is 0 and either `strict_stop` is 0 or the stop bit sampled 1, then `rx_data` takes the byte, `rx_stop` takes the stop bit and `rx_done` becomes 1.
- R8: A frame that completes while `rx_done` is 1 leaves `rx_data`, `rx_stop` and `rx_done` unchanged.
- R9: With `strict_stop` at 1, a frame whose stop bit samples 0 leaves `rx_data`, `rx_stop` and `rx_done` unchanged.
- R10: With `strict_stop` at 0, a frame whose stop bit samples 0 is stored, and `rx_stop` reads 0.
- R11: After reset `txd` is 1 and `tx_done`, `rx_done`, `rx_data`, `rx_stop` and `irq` are 0. The flags fall only on their own clear strobe (`clr_tx_done` or `clr_rx_done`), and one strobe does not affect the other flag.
- R12: `irq` is 1 exactly when `irq_enable` is 1 and at least one of `tx_done` or `rx_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_tick | input | 1 | Transmit 16x oversampling strobe |
| rx_tick | input | 1 | Receive 16x oversampling strobe |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_byte | input | 8 | Byte to transmit |
| rx_enable | input | 1 | Arms the receiver |
| strict_stop | input | 1 | Reject frames whose stop bit samples low |
| clr_tx_done | input | 1 | Clears `tx_done` |
| clr_rx_done | input | 1 | Clears `rx_done` |
| irq_enable | input | 1 | Interrupt request enable |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_done | output | 1 | Sticky receive-done flag |
| rx_data | output | 8 | Last stored received byte |
| rx_stop | output | 1 | Stop bit of the last stored frame |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check five rules on every cycle:
- the transmit flag is set on the cycle after the stop bit begins;
- a write during a frame leaves the shift register alone;
- reception can start only with the receiver enabled;
- a completing frame never overwrites stored data while the flag is set, or when it fails the strict stop check;
- the flags never drop without a clear strobe, and a rising flag drives the interrupt request.

The bench scenarios show what only whole frames can reveal:
- the bit order and bit timing on `txd`;
- the position of the flag within the stop bit;
- majority voting against edge glitches;
- rejection of a false start;
- the mix of stored and dropped frames across the stop-bit and strict-option combinations.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_DATA  = 2'd2,
    PH_STOP  = 2'd3
  } phase_t;

  localparam int unsigned SIO_DATA_W = 8;
  localparam int unsigned SIO_OVS    = 16;

  // Two-of-three majority vote.
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // Mid-bit tick index (0-based): the 8th tick of a bit period.
  function automatic int unsigned mid_tick(input int unsigned ovs);
    return ovs / 2 - 1;
  endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int unsigned DW  = SIO_DATA_W,
  parameter int unsigned OVS = SIO_OVS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_byte,
  output logic          txd,
  output logic          stop_begin
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = (DW > 1) ? $clog2(DW) : 1;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] shreg;
  logic          bit_end;

  assign bit_end    = tick && (cnt == CW'(OVS - 1));
  assign stop_begin = (phase == PH_DATA) && bit_end && (idx == IW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
    end else begin
      if (phase != PH_IDLE && tick) cnt <= bit_end ? '0 : cnt + 1'b1;
      case (phase)
        PH_IDLE: if (wr_en) begin
          shreg <= wr_byte;
          cnt   <= '0;
          phase <= PH_START;
        end
        PH_START: if (bit_end) begin
          idx   <= '0;
          phase <= PH_DATA;
        end
        PH_DATA: if (bit_end) begin
          shreg <= shreg >> 1;
          if (idx == IW'(DW - 1)) phase <= PH_STOP;
          else                    idx   <= idx + 1'b1;
        end
        default: if (bit_end) phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = shreg[0];
      default:  txd = 1'b1;
    endcase
  end

  // R2: a write while a frame is in flight leaves the shift register untouched.
  p_busy_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && wr_en && !bit_end) |=> $stable(shreg));

endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int unsigned DW  = SIO_DATA_W,
  parameter int unsigned OVS = SIO_OVS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_in,
  input  logic          enable,
  output logic          frame_done,
  output logic [DW-1:0] frame_byte,
  output logic          frame_stop
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned IW  = (DW > 1) ? $clog2(DW) : 1;
  localparam int unsigned MID = mid_tick(OVS);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] shreg;
  logic [2:0]    votes;
  logic          s1, s2, s3;
  logic          fall, bit_end, at_mid, busy;

  assign fall       = s3 & ~s2;
  assign bit_end    = tick && (cnt == CW'(OVS - 1));
  assign at_mid     = tick && (cnt == CW'(MID));
  assign busy       = (phase != PH_IDLE);
  assign frame_done = (phase == PH_STOP) && tick && (cnt == CW'(MID + 1));
  assign frame_stop = maj3(votes[0], votes[1], s2);
  assign frame_byte = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      votes <= '0;
    end else begin
      if (busy && tick) begin
        cnt <= bit_end ? '0 : cnt + 1'b1;
        if (cnt == CW'(MID - 1)) votes[0] <= s2;
        if (cnt == CW'(MID))     votes[1] <= s2;
        if (cnt == CW'(MID + 1)) votes[2] <= s2;
      end
      case (phase)
        PH_IDLE: if (enable && fall) begin
          cnt   <= '0;
          phase <= PH_START;
        end
        PH_START: begin
          if (at_mid && s2) phase <= PH_IDLE;
          else if (bit_end) begin
            idx   <= '0;
            phase <= PH_DATA;
          end
        end
        PH_DATA: if (bit_end) begin
          shreg <= {maj3(votes[0], votes[1], votes[2]), shreg[DW-1:1]};
          if (idx == IW'(DW - 1)) phase <= PH_STOP;
          else                    idx   <= idx + 1'b1;
        end
        default: if (frame_done) phase <= PH_IDLE;
      endcase
    end
  end

  // R4: reception only leaves idle when the receiver was enabled.
  p_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(enable));

  // R5: a start bit that reads high at mid-bit sends the receiver back to idle.
  p_false_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_START && at_mid && s2) |=> !busy);

endmodule

// File: rtl/sio_frame_port.sv
module sio_frame_port
  import sio_pkg::*;
#(
  parameter int unsigned DW  = SIO_DATA_W,
  parameter int unsigned OVS = SIO_OVS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_tick,
  input  logic          rx_tick,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_byte,
  input  logic          rx_enable,
  input  logic          strict_stop,
  input  logic          clr_tx_done,
  input  logic          clr_rx_done,
  input  logic          irq_enable,
  input  logic          rxd,
  output logic          txd,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] rx_data,
  output logic          rx_stop,
  output logic          irq
);
  logic          stop_begin;
  logic          frame_done;
  logic [DW-1:0] frame_byte;
  logic          frame_stop;
  logic          accept;

  sio_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .wr_en(wr_en),
    .wr_byte(wr_byte), .txd(txd), .stop_begin(stop_begin)
  );

  sio_rx #(.DW(DW), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .rxd_in(rxd),
    .enable(rx_enable), .frame_done(frame_done),
    .frame_byte(frame_byte), .frame_stop(frame_stop)
  );

  assign accept = frame_done && !rx_done && (!strict_stop || frame_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      rx_data <= '0;
      rx_stop <= 1'b0;
    end else begin
      if (stop_begin)       tx_done <= 1'b1;
      else if (clr_tx_done) tx_done <= 1'b0;
      if (accept) begin
        rx_data <= frame_byte;
        rx_stop <= frame_stop;
        rx_done <= 1'b1;
      end else if (clr_rx_done) begin
        rx_done <= 1'b0;
      end
    end
  end

  assign irq = irq_enable & (tx_done | rx_done);

  // R3: the transmit flag is up on the cycle after the stop bit begins.
  p_txdone_at_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_begin |=> tx_done);

  // R11: flags only fall on their own clear strobe.
  p_tx_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !clr_tx_done) |=> tx_done);
  p_rx_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !clr_rx_done) |=> rx_done);

  // R8: a frame completing over a set flag stores nothing.
  p_hold_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_done) |=> ($stable(rx_data) && $stable(rx_stop)));

  // R9: strict mode drops frames with a low stop bit.
  p_strict_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && strict_stop && !frame_stop) |=>
      ($stable(rx_data) && $stable(rx_stop)));

  // R12: a rising flag with interrupts enabled raises the request.
  p_irq_follows_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(rx_done) || $rose(tx_done)) && irq_enable) |-> irq);

endmodule

// File: tb/sio_frame_port_tb.sv
module sio_frame_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_tick = 1'b0, rx_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       rx_enable = 1'b1, strict_stop = 1'b0;
  logic       clr_tx_done = 1'b0, clr_rx_done = 1'b0;
  logic       irq_enable = 1'b0;
  logic       rxd = 1'b1;
  logic       txd, tx_done, rx_done, rx_stop, irq;
  logic [7:0] rx_data;

  int n_run = 0, n_fail = 0;
  int tcnt = 0;
  logic [7:0] exp_data = '0;
  logic       exp_stop = 1'b0;

  always #2 clk = ~clk;

  // Ticks every 4 cycles; the two directions are out of phase.
  always @(negedge clk) begin
    tcnt    = (tcnt + 1) % 4;
    tx_tick = (tcnt == 3);
    rx_tick = (tcnt == 1);
  end

  sio_frame_port u_dut (
    .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick), .rx_tick(rx_tick),
    .wr_en(wr_en), .wr_byte(wr_byte), .rx_enable(rx_enable),
    .strict_stop(strict_stop), .clr_tx_done(clr_tx_done),
    .clr_rx_done(clr_rx_done), .irq_enable(irq_enable), .rxd(rxd),
    .txd(txd), .tx_done(tx_done), .rx_done(rx_done), .rx_data(rx_data),
    .rx_stop(rx_stop), .irq(irq)
  );

  // {data[10:3], stop[2], strict[1], expect_store[0]}
  localparam logic [10:0] VEC [6] = '{
    {8'hA5, 1'b1, 1'b0, 1'b1},
    {8'h3C, 1'b1, 1'b1, 1'b1},
    {8'h00, 1'b0, 1'b0, 1'b1},
    {8'hFF, 1'b0, 1'b1, 1'b0},
    {8'h81, 1'b1, 1'b1, 1'b1},
    {8'h5A, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_rx();
    @(negedge clk) clr_rx_done = 1'b1;
    @(negedge clk) clr_rx_done = 1'b0;
  endtask

  task automatic clear_tx();
    @(negedge clk) clr_tx_done = 1'b1;
    @(negedge clk) clr_tx_done = 1'b0;
  endtask

  // 64 cycles per bit; the glitch inverts the line near both edges of data bits.
  task automatic send_rx(input logic [7:0] b, input logic stopb, input bit glitch);
    for (int i = 0; i < 10; i++) begin
      logic v;
      v = (i == 0) ? 1'b0 : (i == 9) ? stopb : b[i-1];
      for (int c = 0; c < 64; c++) begin
        @(negedge clk);
        rxd = (glitch && i > 0 && i < 9 && (c < 12 || c >= 52)) ? ~v : v;
      end
    end
    @(negedge clk) rxd = 1'b1;
    repeat (96) @(negedge clk);
  endtask

  task automatic send_tx(input logic [7:0] b, input bit mid_wr, input logic [7:0] b2);
    int guard;
    int wait_n;
    @(negedge clk) begin wr_en = 1'b1; wr_byte = b; end
    @(negedge clk) wr_en = 1'b0;
    guard = 0;
    while (txd && guard < 200) begin @(negedge clk); guard++; end
    wait_n = 32;
    for (int i = 0; i < 10; i++) begin
      logic e;
      repeat (wait_n) @(negedge clk);
      wait_n = 64;
      e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      chk(txd === e, mid_wr ? "R2 frame kept" : "R1 bit", {24'h0, txd}, {24'h0, e});
      if (i == 8) chk(tx_done === 1'b0, "R3 before stop", {31'h0, tx_done}, 0);
      if (i == 9) chk(tx_done === 1'b1, "R3 in stop", {31'h0, tx_done}, 1);
      if (mid_wr && i == 3) begin
        wr_en = 1'b1; wr_byte = b2;
        @(negedge clk) wr_en = 1'b0;
        wait_n = 63;
      end
    end
    repeat (48) @(negedge clk);
    chk(txd === 1'b1, "R1 idle high", {31'h0, txd}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int low_seen;
    repeat (10) @(negedge clk);
    // R11: reset state
    chk(txd === 1'b1 && tx_done === 1'b0 && rx_done === 1'b0, "R11 reset flags",
        {29'h0, txd, tx_done, rx_done}, 32'h4);
    chk(rx_data === 8'h00 && rx_stop === 1'b0 && irq === 1'b0, "R11 reset data",
        {22'h0, rx_data, rx_stop, irq}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R7 / R9 / R10 table
    foreach (VEC[k]) begin
      strict_stop = VEC[k][1];
      clear_rx();
      send_rx(VEC[k][10:3], VEC[k][2], 1'b0);
      if (VEC[k][0]) begin
        exp_data = VEC[k][10:3];
        exp_stop = VEC[k][2];
      end
      chk(rx_done === VEC[k][0], VEC[k][2] ? "R7 flag" : (VEC[k][1] ? "R9 flag" : "R10 flag"),
          {31'h0, rx_done}, {31'h0, VEC[k][0]});
      chk(rx_data === exp_data && rx_stop === exp_stop,
          VEC[k][0] ? "R7 stored" : "R9 unchanged",
          {23'h0, rx_data, rx_stop}, {23'h0, exp_data, exp_stop});
    end

    // R10 then R8: a stored frame is not overwritten while the flag is set
    strict_stop = 1'b0;
    clear_rx();
    send_rx(8'h42, 1'b0, 1'b0);
    chk(rx_data === 8'h42 && rx_stop === 1'b0 && rx_done === 1'b1, "R10 low stop stored",
        {22'h0, rx_data, rx_stop, rx_done}, {22'h0, 8'h42, 2'b01});
    send_rx(8'hEE, 1'b1, 1'b0);
    chk(rx_data === 8'h42 && rx_stop === 1'b0 && rx_done === 1'b1, "R8 held",
        {22'h0, rx_data, rx_stop, rx_done}, {22'h0, 8'h42, 2'b01});

    // R6: glitches outside the mid-bit votes do not matter
    clear_rx();
    send_rx(8'h96, 1'b1, 1'b1);
    chk(rx_data === 8'h96 && rx_done === 1'b1, "R6 majority",
        {23'h0, rx_data, rx_done}, {23'h0, 8'h96, 1'b1});

    // R5: short low pulse is a false start
    clear_rx();
    @(negedge clk) rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (800) @(negedge clk);
    chk(rx_done === 1'b0 && rx_data === 8'h96, "R5 false start",
        {23'h0, rx_data, rx_done}, {23'h0, 8'h96, 1'b0});
    send_rx(8'h17, 1'b1, 1'b0);
    chk(rx_data === 8'h17 && rx_done === 1'b1, "R5 recovers",
        {23'h0, rx_data, rx_done}, {23'h0, 8'h17, 1'b1});

    // R4: disabled receiver ignores a frame
    clear_rx();
    rx_enable = 1'b0;
    send_rx(8'h6B, 1'b1, 1'b0);
    chk(rx_done === 1'b0 && rx_data === 8'h17, "R4 disabled",
        {23'h0, rx_data, rx_done}, {23'h0, 8'h17, 1'b0});
    rx_enable = 1'b1;

    // R1 / R3 transmit frames
    clear_tx();
    send_tx(8'hC5, 1'b0, 8'h00);
    clear_tx();
    send_tx(8'h3A, 1'b0, 8'h00);

    // R2: write during a frame is ignored, no second frame follows
    clear_tx();
    send_tx(8'h69, 1'b1, 8'hF0);
    low_seen = 0;
    for (int c = 0; c < 800; c++) begin
      @(negedge clk);
      if (txd !== 1'b1) low_seen++;
    end
    chk(low_seen == 0, "R2 no extra frame", low_seen, 0);

    // R12: interrupt request
    chk(irq === 1'b0, "R12 masked", {31'h0, irq}, 0);
    @(negedge clk) irq_enable = 1'b1;
    @(negedge clk);
    chk(irq === 1'b1, "R12 tx flag", {31'h0, irq}, 1);

    // R11: clearing one flag leaves the other
    clear_rx();
    send_rx(8'hD2, 1'b1, 1'b0);
    clear_tx();
    @(negedge clk);
    chk(tx_done === 1'b0 && rx_done === 1'b1, "R11 clear tx only",
        {30'h0, tx_done, rx_done}, 32'h1);
    chk(irq === 1'b1, "R12 rx flag", {31'h0, irq}, 1);
    clear_rx();
    @(negedge clk);
    chk(rx_done === 1'b0 && irq === 1'b0, "R12 both clear",
        {30'h0, rx_done, irq}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule